// File: doc/BRIEF.md
# Option ROM and Flash Page Mapper

This block decodes the 20-bit memory space of an 8-bit host bus and steers each access to on-card NOR flash or to one of several small selects. A 16KB option ROM window sits at one of four C-segment bases chosen by a 2-bit switch. Its lower part reads flash page 5. Its top 128 bytes are taken over by a fixed area: IDE bridge registers, RTC access, two mapping registers, and scratch RAM. The mapper drives the flash page number onto flash address bits 18..14. The host supplies address bits 13..0 directly.

The first mapping register controls a second 16KB remap window. Software enables it, places it at any C-segment base, and moves it across 32 flash pages by writing a 5-bit page number. The second mapping register holds eight RAM back-fill enables. These are brought out unchanged for the memory fill logic.

A switch can also serve the top 32KB of memory from flash, as a pair of pages chosen by another switch. Writes that land in any flash window raise a write enable together with chip select, so that software can program the flash.

Top module: `flash_page_mapper`

## Requirements
- R1: After reset the remap window is disabled, the remap register (offset 0x3F94) reads 0x00, and the back-fill register (offset 0x3F95) and the `backFill` output are 0x00.
- R2: With `romEnSw`=1, an access to `0xC0000 + romBaseSw*0x4000 + off`, where off < 0x3F80, asserts `flashCs` with `flashPage`=5.
- R3: In the top area of the option window, offsets 0x3F80–0x3F8F assert `ideSel`, 0x3F90–0x3F93 assert `rtcSel`, and 0x3F96–0x3FFF assert `scratchSel`. `flashCs` stays low across the whole top area, and 0x3F94–0x3F95 assert none of these selects.
- R4: A write to offset 0x3F94 loads the remap register: enable in bit 7, base index in bits 6:5, page in bits 4:0. A read of 0x3F94 or 0x3F95 asserts `regOe` and returns the register on `regDataOut`. Otherwise `regDataOut` is 0x00 and `regOe` is low.
- R5: A write to offset 0x3F95 loads the back-fill register. The next cycle, `backFill` shows the written byte.
- R6: When the remap register is enabled, an access to `0xC0000 + base*0x4000 + off` asserts `flashCs` with `flashPage` equal to the register's page. When it is disabled, that access asserts nothing.
- R7: Where the remap window and the enabled option window overlap, the option window wins: flash page 5 is used, and the top area keeps its selects.
- R8: With `sysEnSw`=1, an access to 0xF8000–0xFFFFF asserts `flashCs` with `flashPage` = `{sysPairSw, addr[14]}`, which gives pages 0/1 or 2/3. With `sysEnSw`=0 that range asserts nothing, and 0xF0000–0xF7FFF never hits.
- R9: With `romEnSw`=0 the option window and its whole top area are absent: no select is raised, and register writes are ignored.
- R10: Selects are raised only while `memRd` or `memWr` is high. `flashWe` is high exactly for writes that assert `flashCs`. `flashPage` is 0 whenever `flashCs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mapping registers |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | Host memory address |
| memRd | input | 1 | Memory read strobe, active high |
| memWr | input | 1 | Memory write strobe, active high |
| wrData | input | 8 | Host write data |
| romBaseSw | input | 2 | Option window base index (C0000 + n*4000h) |
| romEnSw | input | 1 | Enables the option window |
| sysEnSw | input | 1 | Enables top-of-memory flash substitution |
| sysPairSw | input | 1 | Selects page pair 0/1 (0) or 2/3 (1) |
| flashCs | output | 1 | Flash chip select |
| flashWe | output | 1 | Flash write enable |
| flashPage | output | 5 | Flash address bits 18..14 |
| ideSel | output | 1 | IDE bridge register select |
| rtcSel | output | 1 | RTC access select |
| scratchSel | output | 1 | Scratch RAM select |
| regOe | output | 1 | Mapping register read data valid |
| regDataOut | output | 8 | Mapping register read data |
| backFill | output | 8 | RAM back-fill enables |

## Verification
Every select, `flashPage`, `regOe` and `regDataOut` is combinational from the address, strobes, switches and stored registers. The bench therefore drives each access on a falling edge and checks those outputs a short delay later, within the same half cycle. The mapping registers take a write on the next rising edge. A register's effect on `backFill`, on the remap decode or on a readback is checked only after that edge, once the next access has been driven on the following falling edge.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  // offsets inside the 128-byte top area (relative to window offset 0x3F80)
  localparam int IDE_END  = 16;  // 0x00..0x0F
  localparam int RTC_END  = 20;  // 0x10..0x13
  localparam int REMAP_OFF = 20; // 0x14
  localparam int FILL_OFF  = 21; // 0x15
  localparam int REG_END  = 22;  // scratch from 0x16

  typedef struct packed {
    logic selRom;
    logic selRemap;
    logic selSys;
    logic wrRemap;
    logic wrFill;
    logic rdRemap;
    logic rdFill;
  } mapStrobes_t;
endpackage

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WIN_W  = 14,
  parameter int TOP_W  = 7,
  parameter int BASE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              memRd,
  input  logic              memWr,
  input  logic [BASE_W-1:0] romBaseSw,
  input  logic              romEnSw,
  input  logic              sysEnSw,
  input  logic              remapEn,
  input  logic [BASE_W-1:0] remapBase,
  output mapStrobes_t       strb,
  output logic              flashCs,
  output logic              flashWe,
  output logic              ideSel,
  output logic              rtcSel,
  output logic              scratchSel
);
  localparam int SEG_W = ADDR_W - WIN_W;
  localparam int PRE_W = SEG_W - BASE_W;
  localparam logic [PRE_W-1:0] SEG_PREFIX = PRE_W'(4'hC);

  logic             access;
  logic [SEG_W-1:0] segIdx;
  logic [TOP_W-1:0] topOff;
  logic             romHit, topArea, remapHit, sysHit, flashHit, regHit;

  assign access  = memRd | memWr;
  assign segIdx  = addr[ADDR_W-1:WIN_W];
  assign topOff  = addr[TOP_W-1:0];
  assign romHit  = romEnSw && (segIdx == {SEG_PREFIX, romBaseSw});
  assign topArea = romHit && (&addr[WIN_W-1:TOP_W]);
  assign remapHit = remapEn && !romHit && (segIdx == {SEG_PREFIX, remapBase});
  assign sysHit  = sysEnSw && (&addr[ADDR_W-1:WIN_W+1]);
  assign regHit  = topArea && (topOff >= TOP_W'(RTC_END)) && (topOff < TOP_W'(REG_END));

  always_comb begin
    strb          = '0;
    strb.selRom   = access && romHit && !topArea;
    strb.selRemap = access && remapHit;
    strb.selSys   = access && sysHit;
    strb.wrRemap  = memWr && regHit && (topOff == TOP_W'(REMAP_OFF));
    strb.wrFill   = memWr && regHit && (topOff == TOP_W'(FILL_OFF));
    strb.rdRemap  = memRd && regHit && (topOff == TOP_W'(REMAP_OFF));
    strb.rdFill   = memRd && regHit && (topOff == TOP_W'(FILL_OFF));
  end

  assign flashHit   = strb.selRom | strb.selRemap | strb.selSys;
  assign flashCs    = flashHit;
  assign flashWe    = flashHit && memWr;
  assign ideSel     = access && topArea && (topOff < TOP_W'(IDE_END));
  assign rtcSel     = access && topArea && (topOff >= TOP_W'(IDE_END)) && (topOff < TOP_W'(RTC_END));
  assign scratchSel = access && topArea && (topOff >= TOP_W'(REG_END));

  // R3
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flashCs, ideSel, rtcSel, scratchSel}));
  // R10
  we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashWe |-> (flashCs && memWr));
  // R6
  remap_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.selRemap |-> remapEn);
endmodule

// File: rtl/fpm_regs.sv
module fpm_regs
  import fpm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 5,
  parameter int BASE_W   = 2,
  parameter int ROM_PAGE = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobes_t       strb,
  input  logic              pageLsb,
  input  logic              sysPairSw,
  input  logic [DATA_W-1:0] wrData,
  output logic              remapEn,
  output logic [BASE_W-1:0] remapBase,
  output logic [PAGE_W-1:0] flashPage,
  output logic [DATA_W-1:0] regDataOut,
  output logic [DATA_W-1:0] backFill
);
  localparam int EN_BIT = DATA_W - 1;

  logic [DATA_W-1:0] remapReg, fillReg;
  logic [PAGE_W-1:0] remapPage, sysPage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remapReg <= '0;
      fillReg  <= '0;
    end else begin
      if (strb.wrRemap) remapReg <= wrData;
      if (strb.wrFill)  fillReg  <= wrData;
    end
  end

  assign remapEn   = remapReg[EN_BIT];
  assign remapBase = remapReg[EN_BIT-1 -: BASE_W];
  assign remapPage = remapReg[PAGE_W-1:0];
  assign sysPage   = PAGE_W'({sysPairSw, pageLsb});
  assign backFill  = fillReg;

  always_comb begin
    if (strb.selRom)        flashPage = PAGE_W'(ROM_PAGE);
    else if (strb.selRemap) flashPage = remapPage;
    else if (strb.selSys)   flashPage = sysPage;
    else                    flashPage = '0;
  end

  always_comb begin
    if (strb.rdRemap)     regDataOut = remapReg;
    else if (strb.rdFill) regDataOut = fillReg;
    else                  regDataOut = '0;
  end

  // R2
  rom_page_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.selRom |-> (flashPage == PAGE_W'(ROM_PAGE)));
  // R8
  sys_page_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.selSys |-> (flashPage < PAGE_W'(4)));
endmodule

// File: rtl/flash_page_mapper.sv
module flash_page_mapper
  import fpm_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 8,
  parameter int WIN_W    = 14,
  parameter int TOP_W    = 7,
  parameter int PAGE_W   = 5,
  parameter int BASE_W   = 2,
  parameter int ROM_PAGE = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              memRd,
  input  logic              memWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BASE_W-1:0] romBaseSw,
  input  logic              romEnSw,
  input  logic              sysEnSw,
  input  logic              sysPairSw,
  output logic              flashCs,
  output logic              flashWe,
  output logic [PAGE_W-1:0] flashPage,
  output logic              ideSel,
  output logic              rtcSel,
  output logic              scratchSel,
  output logic              regOe,
  output logic [DATA_W-1:0] regDataOut,
  output logic [DATA_W-1:0] backFill
);
  mapStrobes_t       strb;
  logic              remapEn;
  logic [BASE_W-1:0] remapBase;

  fpm_ctrl #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .TOP_W(TOP_W), .BASE_W(BASE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .memRd(memRd), .memWr(memWr),
    .romBaseSw(romBaseSw), .romEnSw(romEnSw), .sysEnSw(sysEnSw),
    .remapEn(remapEn), .remapBase(remapBase), .strb(strb),
    .flashCs(flashCs), .flashWe(flashWe), .ideSel(ideSel),
    .rtcSel(rtcSel), .scratchSel(scratchSel)
  );

  fpm_regs #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .BASE_W(BASE_W), .ROM_PAGE(ROM_PAGE)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .pageLsb(addr[WIN_W]),
    .sysPairSw(sysPairSw), .wrData(wrData), .remapEn(remapEn),
    .remapBase(remapBase), .flashPage(flashPage),
    .regDataOut(regDataOut), .backFill(backFill)
  );

  assign regOe = strb.rdRemap | strb.rdFill;
endmodule

// File: tb/tb_flash_page_mapper.sv
module tb_flash_page_mapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic [19:0] addr = '0;
  logic        memRd = 0, memWr = 0;
  logic [7:0]  wrData = '0;
  logic [1:0]  romBaseSw = '0;
  logic        romEnSw = 1, sysEnSw = 0, sysPairSw = 0;
  logic        flashCs, flashWe, ideSel, rtcSel, scratchSel, regOe;
  logic [4:0]  flashPage;
  logic [7:0]  regDataOut, backFill;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_page_mapper dut (
    .clk(clk), .rstN(rstN), .addr(addr), .memRd(memRd), .memWr(memWr),
    .wrData(wrData), .romBaseSw(romBaseSw), .romEnSw(romEnSw),
    .sysEnSw(sysEnSw), .sysPairSw(sysPairSw), .flashCs(flashCs),
    .flashWe(flashWe), .flashPage(flashPage), .ideSel(ideSel),
    .rtcSel(rtcSel), .scratchSel(scratchSel), .regOe(regOe),
    .regDataOut(regDataOut), .backFill(backFill)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  base;
    logic        romEn, sysEn, pair;
    logic [19:0] a;
    logic        rd, wr;
    logic        cs, we;
    logic [4:0]  page;
    logic        ide, rtc, scr;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  2'd0, 1'b1, 1'b0, 1'b0, 20'hC0000, 1'b1, 1'b0, 1'b1, 1'b0, 5'd5, 1'b0, 1'b0, 1'b0}, // R2
    '{4'd2,  2'd2, 1'b1, 1'b0, 1'b0, 20'hC8123, 1'b1, 1'b0, 1'b1, 1'b0, 5'd5, 1'b0, 1'b0, 1'b0}, // R2
    '{4'd6,  2'd2, 1'b1, 1'b0, 1'b0, 20'hC0000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0}, // R6 remap off
    '{4'd3,  2'd3, 1'b1, 1'b0, 1'b0, 20'hCFF80, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R3
    '{4'd3,  2'd3, 1'b1, 1'b0, 1'b0, 20'hCFF8F, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R3
    '{4'd3,  2'd1, 1'b1, 1'b0, 1'b0, 20'hC7F90, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0}, // R3
    '{4'd3,  2'd1, 1'b1, 1'b0, 1'b0, 20'hC7F93, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0}, // R3
    '{4'd3,  2'd1, 1'b1, 1'b0, 1'b0, 20'hC7F96, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1}, // R3
    '{4'd3,  2'd1, 1'b1, 1'b0, 1'b0, 20'hC7FFF, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1}, // R3
    '{4'd3,  2'd1, 1'b1, 1'b0, 1'b0, 20'hC7F94, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0}, // R3 reg slot
    '{4'd10, 2'd0, 1'b1, 1'b0, 1'b0, 20'hC3F7F, 1'b0, 1'b1, 1'b1, 1'b1, 5'd5, 1'b0, 1'b0, 1'b0}, // R10 write
    '{4'd10, 2'd0, 1'b1, 1'b0, 1'b0, 20'hC0000, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0}, // R10 idle
    '{4'd9,  2'd0, 1'b0, 1'b0, 1'b0, 20'hC3F80, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0}, // R9
    '{4'd8,  2'd0, 1'b1, 1'b1, 1'b0, 20'hF8000, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0}, // R8
    '{4'd8,  2'd0, 1'b1, 1'b1, 1'b0, 20'hFC000, 1'b1, 1'b0, 1'b1, 1'b0, 5'd1, 1'b0, 1'b0, 1'b0}, // R8
    '{4'd8,  2'd0, 1'b1, 1'b1, 1'b1, 20'hFFFFF, 1'b0, 1'b1, 1'b1, 1'b1, 5'd3, 1'b0, 1'b0, 1'b0}, // R8
    '{4'd8,  2'd0, 1'b1, 1'b0, 1'b1, 20'hFFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0}, // R8 off
    '{4'd8,  2'd0, 1'b1, 1'b1, 1'b1, 20'hF4000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0}  // R8 below
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // outputs packed as {cs,we,page,ide,rtc,scr}
  function automatic logic [9:0] outs();
    return {flashCs, flashWe, flashPage, ideSel, rtcSel, scratchSel};
  endfunction

  task automatic access(input logic [19:0] a, input logic rd, input logic wr, input logic [7:0] d);
    @(negedge clk);
    addr = a; memRd = rd; memWr = wr; wrData = d;
    #1;
  endtask

  task automatic regWrite(input logic [19:0] a, input logic [7:0] d);
    access(a, 1'b0, 1'b1, d);
    @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R1: reset state through register readback
    access(20'hC3F94, 1'b1, 1'b0, 8'h00);
    chk("R1", "remap reg", {regOe, regDataOut}, {1'b1, 8'h00});
    access(20'hC3F95, 1'b1, 1'b0, 8'h00);
    chk("R1", "fill reg", {regOe, regDataOut}, {1'b1, 8'h00});
    chk("R1", "backFill", backFill, 8'h00);
    access(20'hCC010, 1'b1, 1'b0, 8'h00);
    chk("R1", "remap disabled", outs(), 10'h000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      romBaseSw = VECS[i].base; romEnSw = VECS[i].romEn;
      sysEnSw = VECS[i].sysEn; sysPairSw = VECS[i].pair;
      addr = VECS[i].a; memRd = VECS[i].rd; memWr = VECS[i].wr; wrData = 8'h00;
      #1;
      checks++;
      if (outs() !== {VECS[i].cs, VECS[i].we, VECS[i].page, VECS[i].ide, VECS[i].rtc, VECS[i].scr}) begin
        errors++;
        $display("FAIL R%0d vector %0d actual=%0h expected=%0h", VECS[i].req, i, outs(),
                 {VECS[i].cs, VECS[i].we, VECS[i].page, VECS[i].ide, VECS[i].rtc, VECS[i].scr});
      end
    end
    romBaseSw = 2'd0; romEnSw = 1; sysEnSw = 0; sysPairSw = 0;

    // R4: remap register write: en=1, base=3, page=3 -> 0xE3
    regWrite(20'hC3F94, 8'hE3);
    access(20'hC3F94, 1'b1, 1'b0, 8'h00);
    chk("R4", "remap readback", {regOe, regDataOut}, {1'b1, 8'hE3});
    access(20'hC3F00, 1'b1, 1'b0, 8'h00);
    chk("R4", "no readback outside regs", {regOe, regDataOut}, {1'b0, 8'h00});

    // R6: remap window at CC000 uses page 3; writes raise flashWe
    access(20'hCC010, 1'b1, 1'b0, 8'h00);
    chk("R6", "remap read", outs(), {1'b1, 1'b0, 5'd3, 3'b000});
    access(20'hCFFFF, 1'b0, 1'b1, 8'h00);
    chk("R6", "remap write top", outs(), {1'b1, 1'b1, 5'd3, 3'b000});

    // R5: back-fill register
    regWrite(20'hC3F95, 8'h5A);
    access(20'hC3F95, 1'b1, 1'b0, 8'h00);
    chk("R5", "backFill out", backFill, 8'h5A);
    chk("R5", "fill readback", {regOe, regDataOut}, {1'b1, 8'h5A});

    // R7: option window at the same base wins
    @(negedge clk); romBaseSw = 2'd3;
    access(20'hCC010, 1'b1, 1'b0, 8'h00);
    chk("R7", "overlap page", outs(), {1'b1, 1'b0, 5'd5, 3'b000});
    access(20'hCFF85, 1'b1, 1'b0, 8'h00);
    chk("R7", "overlap top area", outs(), {1'b0, 1'b0, 5'd0, 3'b100});
    @(negedge clk); romBaseSw = 2'd0;

    // R6: disable remap, same page and base otherwise
    regWrite(20'hC3F94, 8'h63);
    access(20'hCC010, 1'b1, 1'b0, 8'h00);
    chk("R6", "remap disabled", outs(), 10'h000);
    regWrite(20'hC3F94, 8'h9F); // en, base 0 -> overlaps option window at C0000
    access(20'hC1000, 1'b1, 1'b0, 8'h00);
    chk("R7", "overlap base0", outs(), {1'b1, 1'b0, 5'd5, 3'b000});
    regWrite(20'hC3F94, 8'hBF); // en, base 1, page 31
    access(20'hC4000, 1'b1, 1'b0, 8'h00);
    chk("R6", "remap page 31", outs(), {1'b1, 1'b0, 5'd31, 3'b000});

    // R9: register write ignored while option window is off
    @(negedge clk); romEnSw = 0;
    regWrite(20'hC3F94, 8'h00);
    access(20'hC3F94, 1'b1, 1'b0, 8'h00);
    chk("R9", "no regOe when off", {regOe, regDataOut}, {1'b0, 8'h00});
    @(negedge clk); romEnSw = 1;
    access(20'hC3F94, 1'b1, 1'b0, 8'h00);
    chk("R9", "reg kept", {regOe, regDataOut}, {1'b1, 8'hBF});

    // R10: strobes low -> nothing, even in remap window
    access(20'hC4000, 1'b0, 1'b0, 8'h00);
    chk("R10", "idle remap", outs(), 10'h000);

    // R1: reset again clears everything
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    access(20'hC3F94, 1'b1, 1'b0, 8'h00);
    chk("R1", "remap after reset", regDataOut, 8'h00);
    chk("R1", "backFill after reset", backFill, 8'h00);

    access(20'h00000, 1'b0, 1'b0, 8'h00);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule